// File: doc/BRIEF.md
# Serial Configuration Register Port with Burst Access

This block lets an external host read and write a bank of 16-bit configuration registers over a four-wire serial bus (chip select, serial clock, data in, data out). Every transfer opens with a 16-bit command word. Its top bit chooses the direction and the remaining 15 bits give a starting register address. One or more 16-bit data words follow. After the first data word, each further word goes to the next address, for as long as chip select stays low.

The bus pins are asynchronous to the block's system clock. They pass through synchronizers and are then edge-detected. Data is captured on the rising serial-clock edge and launched on the falling edge (mode 0). The register bank sits inside the block. Its contents are visible as a flat vector to the logic being configured. Only the lowest `NUM_REGS` addresses hold storage. The data output has an explicit enable and is high-impedance outside the data words of a read.

Top module: `spi_cfg_slave`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), the output enable is low and every register is cleared to 0x0000. A reset in the middle of a transfer abandons that transfer.
- R2: Within two system clocks after synchronized chip select goes high, `spi_miso_oe` is low, and it stays low while chip select is high.
- R3: A frame whose command bit 15 is 0 writes the following 16 bits (MSB first) into the register at command bits 14:0.
- R4: A frame whose command bit 15 is 1 returns the addressed register MSB first, one bit per serial clock, starting with the first clock after the command word. Each bit changes only after a falling serial-clock edge, so it is stable across the rising edge.
- R5: In a write, every further complete 16-bit word while chip select stays low goes to the previous address plus one.
- R6: In a read, every further 16-bit word while chip select stays low returns the register at the previous address plus one.
- R7: A data word is committed only after all 16 of its bits have been received. A word cut short by chip select rising leaves every register unchanged.
- R8: Addresses at or above `NUM_REGS` read back as 0x0000, and writes to them change no register.
- R9: The address pointer wraps from 0x7FFF to 0x0000 during a burst.
- R10: `spi_miso_oe` is high only during the data words of a read frame. It is low during the command word and throughout write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high-impedance when not enabled |
| spi_miso_oe | output | 1 | Drive enable of `spi_miso` |
| cfg_regs | output | NUM_REGS*DATA_W | Register contents, register i at bits i*DATA_W +: DATA_W |

## Verification
The bench builds the block with its default values: 16 implemented registers, a 15-bit address and two synchronizer stages. With 16 registers, a burst that starts at register 15 crosses into unimplemented space after one word. The full 15-bit address makes the 0x7FFF-to-0x0000 wrap reachable in a two-word burst. The serial clock runs at one sixteenth of the system clock, so the synchronizer delay stays well inside each half period. This lets the bench sample the data output just before each rising edge and again just before each falling edge.

// File: rtl/spi_cfg_pkg.sv
// Package: shared widths and the frame phase type of the serial
// configuration port. Assumes a command word of one direction bit plus
// the address.
package spi_cfg_pkg;

    localparam int unsigned CFG_ADDR_W = 15;
    localparam int unsigned CFG_DATA_W = 16;

    // Which word of the frame is being shifted.
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } frame_phase_e;

endpackage

// File: rtl/spi_cfg_sync.sv
// Module: multi-stage synchronizer for a vector of independent
// asynchronous inputs. Each bit gets its own flop chain, and the reset
// value is chosen per bit. Assumes STAGES >= 2 and that the bits need
// no mutual coherence.
module spi_cfg_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the chain of flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], d_async[g]};
            end
        end

        assign q_sync[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_cfg_regbank.sv
// Module: configuration register bank. There are NUM_REGS words of
// DATA_W bits at addresses 0..NUM_REGS-1. Writes take effect one clock
// after the strobe. The read port is combinational and returns zero
// above the implemented range. Assumes NUM_REGS >= 2.
module spi_cfg_regbank #(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(r));

        // Hold one register and load it when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[r] <= '0;
            end else if (hit) begin
                regs[r] <= wr_data;
            end
        end

        assign regs_flat[r*DATA_W +: DATA_W] = regs[r];
    end

    // Select the addressed register, or zero outside the bank.
    always_comb begin
        if (rd_addr < ADDR_W'(NUM_REGS)) begin
            rd_data = regs[rd_addr[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/spi_cfg_frame.sv
// Module: serial frame engine. It works on synchronized bus levels,
// detects serial-clock edges, assembles the command word, runs the
// auto-incrementing address pointer, issues register writes and
// shifts read data out on falling edges. Assumes the system clock is
// fast enough that no two serial edges share one system cycle.
module spi_cfg_frame
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso_q,
    output logic              miso_oe,
    output logic              cs_act,
    output logic              sclk_rise,
    output logic              sclk_fall
);

    localparam int unsigned CMD_W = ADDR_W + 1;
    localparam int unsigned MAX_W = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int unsigned CNT_W = $clog2(MAX_W);

    logic                sclk_prev;
    frame_phase_e        phase;
    logic                rd_flag;
    logic [CNT_W-1:0]    bit_cnt;
    logic [MAX_W-1:0]    rx_sr;
    logic [MAX_W-1:0]    rx_next;
    logic [ADDR_W-1:0]   ptr;
    logic [DATA_W-1:0]   tx_sr;
    logic                last_bit;
    logic                cmd_read;
    logic [ADDR_W-1:0]   cmd_addr;

    assign cs_act    = !cs_n_s;
    assign sclk_rise = cs_act && sclk_s && !sclk_prev;
    assign sclk_fall = cs_act && !sclk_s && sclk_prev;
    assign rx_next   = {rx_sr[MAX_W-2:0], mosi_s};
    assign cmd_read  = rx_next[CMD_W-1];
    assign cmd_addr  = rx_next[ADDR_W-1:0];

    // Flag the final bit of the word currently being shifted.
    always_comb begin
        if (phase == PH_CMD) begin
            last_bit = (bit_cnt == CNT_W'(CMD_W - 1));
        end else begin
            last_bit = (bit_cnt == CNT_W'(DATA_W - 1));
        end
    end

    // Point the read port at the word that will be shifted out next.
    always_comb begin
        if (phase == PH_CMD) begin
            rd_addr = cmd_addr;
        end else begin
            rd_addr = ptr + 1'b1;
        end
    end

    // Remember the serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
        end
    end

    // Track bit position, word phase, direction and address pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            phase   <= PH_CMD;
            rd_flag <= 1'b0;
            ptr     <= '0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
            phase   <= PH_CMD;
            rd_flag <= 1'b0;
        end else if (sclk_rise) begin
            if (!last_bit) begin
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                bit_cnt <= '0;
                if (phase == PH_CMD) begin
                    phase   <= PH_DATA;
                    rd_flag <= cmd_read;
                    ptr     <= cmd_addr;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end

    // Collect incoming bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (!cs_act) begin
            rx_sr <= '0;
        end else if (sclk_rise) begin
            rx_sr <= rx_next;
        end
    end

    // Issue one write strobe per completed data word of a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (cs_act && sclk_rise && last_bit
                && phase == PH_DATA && !rd_flag) begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= rx_next[DATA_W-1:0];
            end
        end
    end

    // Load read data at word ends and present one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            miso_q <= 1'b0;
        end else if (!cs_act) begin
            tx_sr  <= '0;
            miso_q <= 1'b0;
        end else if (sclk_rise && last_bit) begin
            if ((phase == PH_CMD && cmd_read) || (phase == PH_DATA && rd_flag)) begin
                tx_sr <= rd_data;
            end
        end else if (sclk_fall && phase == PH_DATA && rd_flag) begin
            miso_q <= tx_sr[DATA_W-1];
            tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
        end
    end

    // Enable the output driver only during the data words of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso_oe <= 1'b0;
        end else begin
            miso_oe <= cs_act && (phase == PH_DATA) && rd_flag;
        end
    end

endmodule

// File: rtl/spi_cfg_slave.sv
// Module: top of the serial configuration port. It synchronizes the
// bus pins, runs the frame engine against the internal register bank
// and drives the shared data-out line only while the engine enables
// it. Assumes SYNC_STAGES >= 2 and a system clock at least 8x sclk.
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = CFG_ADDR_W,
    parameter int unsigned DATA_W      = CFG_DATA_W,
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sclk,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    output logic                       spi_miso_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);

    localparam int unsigned PIN_W = 3;
    localparam logic [PIN_W-1:0] PIN_RST = 3'b100;

    logic [PIN_W-1:0]  pins_s;
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              miso_q;

    spi_cfg_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_cs_n, spi_sclk, spi_mosi}),
        .q_sync  (pins_s)
    );

    spi_cfg_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso_q    (miso_q),
        .miso_oe   (spi_miso_oe),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    spi_cfg_regbank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

    // Release the shared line whenever the driver is not enabled.
    assign spi_miso = spi_miso_oe ? miso_q : 1'bz;

endmodule

// File: rtl/spi_cfg_checker.sv
// Module: property checker for the serial configuration port. It is
// attached to every spi_cfg_slave by the bind at the end of this file.
// Assumes the signal names of the top module.
module spi_cfg_checker #(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NUM_REGS = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_act,
    input logic                       sclk_rise,
    input logic                       sclk_fall,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic                       miso_q,
    input logic                       miso_oe,
    input logic [NUM_REGS*DATA_W-1:0] cfg_regs
);

    // Reset releases the output driver on the next clock.
    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> !miso_oe);

    // An idle chip select keeps the driver released.
    assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe);

    // The output bit moves only right after a falling serial edge.
    assert_launch_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$stable(miso_q)) |-> $past(sclk_fall));

    // A write strobe always follows a completed rising-edge bit.
    assert_commit_after_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(sclk_rise));

    // Writes outside the bank leave all storage untouched.
    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(cfg_regs));

    // The driver turns on two cycles after the closing command edge.
    assert_drive_after_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> $past(sclk_rise, 2));

endmodule

bind spi_cfg_slave spi_cfg_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_spi_cfg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .miso_q    (miso_q),
    .miso_oe   (spi_miso_oe),
    .cfg_regs  (cfg_regs)
);

// File: tb/test_spi_cfg_slave.sv
// Bench: directed scenarios for spi_cfg_slave, one task each. The
// expected register contents come from a model kept in the bench.
module test_spi_cfg_slave;

    localparam int NREG = 16;
    localparam int DW   = 16;
    localparam int HALF = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spi_cs_n = 1'b1;
    logic              spi_sclk = 1'b0;
    logic              spi_mosi = 1'b0;
    wire               spi_miso;
    logic              spi_miso_oe;
    logic [NREG*DW-1:0] cfg_regs;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [DW-1:0] model [NREG];

    logic          w_oe_any;
    logic          w_oe_all;
    logic          w_stable;

    spi_cfg_slave #(
        .NUM_REGS    (NREG),
        .SYNC_STAGES (2)
    ) i_spi_cfg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .cfg_regs    (cfg_regs)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_regs[i*DW +: DW] !== model[i]) begin
                if (ok) bad = i;
                ok = 1'b0;
            end
        end
        check(ok, req, $sformatf("register %0d", bad),
              32'(cfg_regs[bad*DW +: DW]), 32'(model[bad]));
    endtask

    // One serial bit: set data, sample before the rise, resample before the fall.
    task automatic xfer_bit(input logic b, output logic o);
        logic late;
        spi_mosi = b;
        wait_clks(HALF);
        o = spi_miso;
        if (spi_miso_oe) w_oe_any = 1'b1; else w_oe_all = 1'b0;
        spi_sclk = 1'b1;
        wait_clks(HALF - 1);
        late = spi_miso;
        if (spi_miso_oe && late !== o) w_stable = 1'b0;
        wait_clks(1);
        spi_sclk = 1'b0;
    endtask

    task automatic xfer_word(input logic [DW-1:0] w, input int nbits,
                             output logic [DW-1:0] r);
        logic o;
        w_oe_any = 1'b0;
        w_oe_all = 1'b1;
        w_stable = 1'b1;
        r = '0;
        for (int i = 0; i < nbits; i++) begin
            xfer_bit(w[DW-1-i], o);
            r = {r[DW-2:0], o};
        end
    endtask

    task automatic cs_open();
        spi_cs_n = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic cs_close();
        wait_clks(HALF);
        spi_cs_n = 1'b1;
        wait_clks(2 * HALF);
    endtask

    task automatic t_reset();
        check(spi_miso_oe === 1'b0, "R1", "oe after reset", 32'(spi_miso_oe), 32'd0);
        check_regs("R1");
    endtask

    task automatic t_single_write();
        logic [DW-1:0] r;
        cs_open();
        xfer_word({1'b0, 15'd3}, 16, r);
        xfer_word(16'hA5C3, 16, r);
        check(!w_oe_any, "R10", "oe during write data", 32'(w_oe_any), 32'd0);
        cs_close();
        model[3] = 16'hA5C3;
        check_regs("R3");
    endtask

    task automatic t_single_read();
        logic [DW-1:0] r;
        cs_open();
        xfer_word({1'b1, 15'd3}, 16, r);
        check(!w_oe_any, "R10", "oe during command", 32'(w_oe_any), 32'd0);
        xfer_word(16'h0000, 16, r);
        check(r === model[3], "R4", "read data", 32'(r), 32'(model[3]));
        check(w_oe_all, "R10", "oe through read data", 32'(w_oe_all), 32'd1);
        check(w_stable, "R4", "bit stable over high phase", 32'(w_stable), 32'd1);
        cs_close();
        check(spi_miso_oe === 1'b0, "R2", "oe after select released",
              32'(spi_miso_oe), 32'd0);
    endtask

    task automatic t_burst_write();
        logic [DW-1:0] r;
        logic [DW-1:0] vals [3];
        vals[0] = 16'h1234; vals[1] = 16'h5678; vals[2] = 16'h9ABC;
        cs_open();
        xfer_word({1'b0, 15'd5}, 16, r);
        for (int i = 0; i < 3; i++) begin
            xfer_word(vals[i], 16, r);
            model[5 + i] = vals[i];
        end
        cs_close();
        check_regs("R5");
    endtask

    task automatic t_burst_read();
        logic [DW-1:0] r;
        cs_open();
        xfer_word({1'b1, 15'd4}, 16, r);
        for (int i = 0; i < 4; i++) begin
            xfer_word(16'h0000, 16, r);
            check(r === model[4 + i], "R6", $sformatf("burst word %0d", i),
                  32'(r), 32'(model[4 + i]));
        end
        cs_close();
        check(spi_miso_oe === 1'b0, "R2", "oe after burst", 32'(spi_miso_oe), 32'd0);
    endtask

    task automatic t_truncated();
        logic [DW-1:0] r;
        cs_open();
        xfer_word({1'b0, 15'd9}, 16, r);
        xfer_word(16'h1111, 16, r);
        xfer_word(16'h2222, 7, r);
        cs_close();
        model[9] = 16'h1111;
        check_regs("R7");
        check(cfg_regs[10*DW +: DW] === 16'h0000, "R7", "cut word reg 10",
              32'(cfg_regs[10*DW +: DW]), 32'd0);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] r;
        cs_open();
        xfer_word({1'b0, 15'h0100}, 16, r);
        xfer_word(16'hFFFF, 16, r);
        cs_close();
        check_regs("R8");
        cs_open();
        xfer_word({1'b1, 15'h0100}, 16, r);
        xfer_word(16'h0000, 16, r);
        cs_close();
        check(r === 16'h0000, "R8", "unmapped read", 32'(r), 32'd0);
        cs_open();
        xfer_word({1'b1, 15'd15}, 16, r);
        xfer_word(16'h0000, 16, r);
        check(r === model[15], "R8", "last mapped word", 32'(r), 32'(model[15]));
        xfer_word(16'h0000, 16, r);
        check(r === 16'h0000, "R8", "burst past bank", 32'(r), 32'd0);
        cs_close();
    endtask

    task automatic t_wrap();
        logic [DW-1:0] r;
        cs_open();
        xfer_word({1'b0, 15'h7FFF}, 16, r);
        xfer_word(16'hDEAD, 16, r);
        xfer_word(16'hBEEF, 16, r);
        cs_close();
        model[0] = 16'hBEEF;
        check_regs("R9");
        cs_open();
        xfer_word({1'b1, 15'h7FFF}, 16, r);
        xfer_word(16'h0000, 16, r);
        check(r === 16'h0000, "R9", "read at top address", 32'(r), 32'd0);
        xfer_word(16'h0000, 16, r);
        check(r === 16'hBEEF, "R9", "read after wrap", 32'(r), 32'h0000BEEF);
        cs_close();
    endtask

    task automatic t_reset_mid_frame();
        logic [DW-1:0] r;
        cs_open();
        xfer_word({1'b1, 15'd5}, 16, r);
        xfer_word(16'h0000, 8, r);
        rst_n = 1'b0;
        wait_clks(4);
        check(spi_miso_oe === 1'b0, "R1", "oe during mid-frame reset",
              32'(spi_miso_oe), 32'd0);
        rst_n = 1'b1;
        cs_close();
        for (int i = 0; i < NREG; i++) model[i] = '0;
        check_regs("R1");
        cs_open();
        xfer_word({1'b1, 15'd3}, 16, r);
        xfer_word(16'h0000, 16, r);
        cs_close();
        check(r === 16'h0000, "R1", "read after reset", 32'(r), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        wait_clks(5);
        t_reset();
        rst_n = 1'b1;
        wait_clks(4);
        t_single_write();
        t_single_read();
        t_burst_write();
        t_burst_read();
        t_truncated();
        t_unmapped();
        t_wrap();
        t_reset_mid_frame();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog all-requirements actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule